// File: doc/BRIEF.md
# Accumulator Saturation and Condition-Flag Unit

This unit sits between the arithmetic datapath of a data ALU and its accumulator registers. The accumulator is 36 bits wide: a 4-bit guard extension on top of a 32-bit word, which is a 16-bit high half and a 16-bit low half. On every write-back the unit decides what value is stored. When limiting is enabled, a data-ALU result that does not fit the signed 32-bit word is replaced by the nearest 32-bit extreme, with the guard bits holding only copies of the sign. A move-class write-back always passes through untouched.

The unit also produces the condition flags for data-ALU write-backs. A mode input chooses whether negative, zero, overflow and carry are judged over the full 36 bits or over the 32-bit word alone. Unsigned branch conditions are only meaningful with flags from the 32-bit view. A sticky limit flag gathers every overflow until an explicit clear. The stored value and all the flags are registered and change on the clock edge that takes the write-back.

Top module: `acc_limit_flags`

## Requirements
- R1: While reset is asserted and after it is released, `acc_out` is zero and every flag output is 0.
- R2: When `wb_valid` is 1 at a rising clock edge, the outputs show that write-back's results from that edge on. When `wb_valid` is 0, `acc_out` and all flags keep their values.
- R3: For a data-ALU write-back (`wb_is_move`=0) with `sat_en`=1, a result whose signed value exceeds 2^31-1 is stored as 0x0_7FFF_FFFF, and one below -2^31 is stored as 0xF_8000_0000. A result in range is stored unchanged.
- R4: With `sat_en`=0, a data-ALU result is stored exactly as it arrives, including any guard bits that disagree with bit 31.
- R5: A move-class write-back (`wb_is_move`=1) stores `res_in` unchanged whatever `sat_en` is. It leaves flags E, U, N, Z, V, C and L as they were.
- R6: V is 1 when limiting took place. Otherwise, V is bits 35..31 of `res_in` not all equal when `cc32`=1, and V is `ovf36_in` when `cc32`=0.
- R7: U is 1 when bits 31 and 30 of the stored value are equal, and is forced to 0 when limiting took place.
- R8: N is bit 31 of the stored value when `cc32`=1, and bit 35 when `cc32`=0.
- R9: Z is 1 when bits 31..0 of the stored value are all zero (`cc32`=1), or when all 36 bits are zero (`cc32`=0). The guard bits are ignored in the first case.
- R10: E is 1 when bits 35..31 of the stored value are not all equal, in either mode.
- R11: C is `carry32_in` when `cc32`=1 and `carry36_in` when `cc32`=0.
- R12: L is set by any data-ALU write-back whose V is 1. It falls only on a clock edge with `l_clr`=1, with or without a write-back. When clear and a new overflow meet at the same edge, L ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_valid | input | 1 | A write-back is taken at this edge |
| wb_is_move | input | 1 | 1: move-class write-back, 0: data-ALU result |
| sat_en | input | 1 | Enables the 32-bit limiter |
| cc32 | input | 1 | 1: flags over 32 bits, 0: flags over 36 bits |
| ovf36_in | input | 1 | Overflow of the full 36-bit operation, from the datapath |
| carry36_in | input | 1 | Carry out of bit 35, from the datapath |
| carry32_in | input | 1 | Carry out of bit 31, from the datapath |
| l_clr | input | 1 | Clears the sticky limit flag |
| res_in | input | 36 | Result to be written back |
| acc_out | output | 36 | Stored accumulator value |
| flag_e | output | 1 | Extension in use |
| flag_u | output | 1 | Unnormalized |
| flag_n | output | 1 | Negative |
| flag_z | output | 1 | Zero |
| flag_v | output | 1 | Overflow |
| flag_c | output | 1 | Carry |
| flag_l | output | 1 | Sticky limit |

## Verification
The main sweep covers every value of the top seven result bits (35..29). Each is combined with three fills of the low 29 bits: all zeros, all ones and alternating. Every combination is tried in each of the eight settings of move class, limiter enable and flag mode. The all-ones and all-zeros fills land exactly on the largest and smallest values that still fit 32 bits, and on the first values past them, so clamp errors off by one are caught. Running the same guard-bit patterns under both flag modes shows whether N, Z and V read the guard bits. Running them as moves shows whether the limiter or the flag update leaks into the bypass path. Directed steps check hold without a write-back, and clearing L with and without a new overflow at the same edge.

// File: rtl/acc_sat_pkg.sv
package acc_sat_pkg;
  parameter int unsigned EXT_W = 4;
  parameter int unsigned MSP_W = 16;
  parameter int unsigned LSP_W = 16;

  localparam int unsigned WORD_W = MSP_W + LSP_W;
  localparam int unsigned ACC_W  = EXT_W + WORD_W;
  localparam int unsigned TOP_W  = EXT_W + 1;   // guard bits plus word sign

  typedef logic [ACC_W-1:0] acc_t;

  typedef struct packed {
    logic e;
    logic u;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;

  // True when the guard bits are not pure sign copies of bit WORD_W-1
  function automatic logic guard_mismatch(input acc_t x);
    logic [TOP_W-1:0] t;
    t = x[ACC_W-1 -: TOP_W];
    return !((t == '0) || (t == '1));
  endfunction

  // Word extreme on the side given by the sign, sign-extended into the guard
  function automatic acc_t word_extreme(input logic neg);
    acc_t r;
    r = '0;
    if (neg) r[ACC_W-1:WORD_W-1] = '1;
    else     r[WORD_W-2:0]       = '1;
    return r;
  endfunction
endpackage

// File: rtl/acc_limiter.sv
module acc_limiter
  import acc_sat_pkg::*;
(
  input  acc_t raw_i,
  input  logic sat_en_i,
  input  logic alu_op_i,
  output acc_t value_o,
  output logic sat_hit_o
);
  logic out_of_word;

  assign out_of_word = guard_mismatch(raw_i);
  assign sat_hit_o   = sat_en_i & alu_op_i & out_of_word;
  assign value_o     = sat_hit_o ? word_extreme(raw_i[ACC_W-1]) : raw_i;
endmodule

// File: rtl/acc_flag_calc.sv
module acc_flag_calc
  import acc_sat_pkg::*;
(
  input  acc_t stored_i,
  input  acc_t raw_i,
  input  logic cc32_i,
  input  logic sat_hit_i,
  input  logic ovf36_i,
  input  logic carry36_i,
  input  logic carry32_i,
  output ccr_t flags_o
);
  logic word_zero;
  logic full_zero;

  assign word_zero = (stored_i[WORD_W-1:0] == '0);
  assign full_zero = word_zero & (stored_i[ACC_W-1:WORD_W] == '0);

  always_comb begin
    flags_o.e = guard_mismatch(stored_i);
    flags_o.u = ~sat_hit_i & (stored_i[WORD_W-1] == stored_i[WORD_W-2]);
    flags_o.n = cc32_i ? stored_i[WORD_W-1] : stored_i[ACC_W-1];
    flags_o.z = cc32_i ? word_zero : full_zero;
    flags_o.v = sat_hit_i | (cc32_i ? guard_mismatch(raw_i) : ovf36_i);
    flags_o.c = cc32_i ? carry32_i : carry36_i;
  end
endmodule

// File: rtl/acc_sticky_limit.sv
module acc_sticky_limit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic l_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) l_o <= 1'b0;
    else        l_o <= (l_o & ~clr_i) | set_i;
  end

  a_r12_l_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (l_o && !clr_i) |=> l_o);
  a_r12_l_sets: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> l_o);
endmodule

// File: rtl/acc_limit_flags.sv
module acc_limit_flags
  import acc_sat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wb_valid,
  input  logic             wb_is_move,
  input  logic             sat_en,
  input  logic             cc32,
  input  logic             ovf36_in,
  input  logic             carry36_in,
  input  logic             carry32_in,
  input  logic             l_clr,
  input  logic [ACC_W-1:0] res_in,
  output logic [ACC_W-1:0] acc_out,
  output logic             flag_e,
  output logic             flag_u,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_v,
  output logic             flag_c,
  output logic             flag_l
);
  // named internal events, visible to the assertions
  logic alu_wb;
  logic sat_hit;
  acc_t limited;
  ccr_t next_flags;
  ccr_t ccr_q;
  acc_t acc_q;

  assign alu_wb = wb_valid & ~wb_is_move;

  acc_limiter u_limiter (
    .raw_i     (res_in),
    .sat_en_i  (sat_en),
    .alu_op_i  (~wb_is_move),
    .value_o   (limited),
    .sat_hit_o (sat_hit)
  );

  acc_flag_calc u_flags (
    .stored_i  (limited),
    .raw_i     (res_in),
    .cc32_i    (cc32),
    .sat_hit_i (sat_hit),
    .ovf36_i   (ovf36_in),
    .carry36_i (carry36_in),
    .carry32_i (carry32_in),
    .flags_o   (next_flags)
  );

  acc_sticky_limit u_sticky (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (alu_wb & next_flags.v),
    .clr_i (l_clr),
    .l_o   (flag_l)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      ccr_q <= '0;
    end else begin
      if (wb_valid) acc_q <= limited;
      if (alu_wb)   ccr_q <= next_flags;
    end
  end

  assign acc_out = acc_q;
  assign flag_e  = ccr_q.e;
  assign flag_u  = ccr_q.u;
  assign flag_n  = ccr_q.n;
  assign flag_z  = ccr_q.z;
  assign flag_v  = ccr_q.v;
  assign flag_c  = ccr_q.c;

  a_r2_hold_acc: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_valid |=> $stable(acc_out));
  a_r3_stored_fits: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_wb && sat_en) |=> !flag_e);
  a_r5_move_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_is_move) |=> (acc_out == $past(res_in)) && $stable(flag_v) && $stable(flag_z));
  a_r6_sat_sets_v: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_wb && sat_hit) |=> (flag_v && !flag_u));
  a_r4_no_limit_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !sat_en) |=> (acc_out == $past(res_in)));
endmodule

// File: tb/acc_limit_flags_bench.sv
module acc_limit_flags_bench;
  localparam int CLK_NS = 10;
  localparam int WD_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst_n;
  logic wb_valid, wb_is_move, sat_en, cc32, ovf36_in, carry36_in, carry32_in, l_clr;
  logic [35:0] res_in, acc_out;
  logic flag_e, flag_u, flag_n, flag_z, flag_v, flag_c, flag_l;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // model state
  logic [35:0] m_acc;
  logic m_e, m_u, m_n, m_z, m_v, m_c, m_l;

  always #(CLK_NS/2) clk = ~clk;

  acc_limit_flags u_acc_limit_flags (
    .clk(clk), .rst_n(rst_n), .wb_valid(wb_valid), .wb_is_move(wb_is_move),
    .sat_en(sat_en), .cc32(cc32), .ovf36_in(ovf36_in), .carry36_in(carry36_in),
    .carry32_in(carry32_in), .l_clr(l_clr), .res_in(res_in), .acc_out(acc_out),
    .flag_e(flag_e), .flag_u(flag_u), .flag_n(flag_n), .flag_z(flag_z),
    .flag_v(flag_v), .flag_c(flag_c), .flag_l(flag_l)
  );

  function automatic longint as_signed(input logic [35:0] x);
    longint r;
    r = longint'(x);
    if (x[35]) r = r - (longint'(1) <<< 36);
    return r;
  endfunction

  function automatic bit in_word(input logic [35:0] x);
    longint s;
    s = as_signed(x);
    return (s >= -(longint'(1) <<< 31)) && (s <= (longint'(1) <<< 31) - 1);
  endfunction

  task automatic cmp(input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string acc_tag, input string fl_tag);
    cmp(acc_tag, acc_out, m_acc);
    cmp({fl_tag, " R10 E"}, {35'd0, flag_e}, {35'd0, m_e});
    cmp({fl_tag, " R7 U"},  {35'd0, flag_u}, {35'd0, m_u});
    cmp({fl_tag, " R8 N"},  {35'd0, flag_n}, {35'd0, m_n});
    cmp({fl_tag, " R9 Z"},  {35'd0, flag_z}, {35'd0, m_z});
    cmp({fl_tag, " R6 V"},  {35'd0, flag_v}, {35'd0, m_v});
    cmp({fl_tag, " R11 C"}, {35'd0, flag_c}, {35'd0, m_c});
    cmp({fl_tag, " R12 L"}, {35'd0, flag_l}, {35'd0, m_l});
  endtask

  // drive at a falling edge, model the next rising edge, compare at the next falling edge
  task automatic step(input bit valid, input bit mv, input bit sat, input bit cc,
                      input bit ovf, input bit c36, input bit c32, input bit clr,
                      input logic [35:0] raw);
    logic [35:0] st;
    bit hit, vv;
    string at, ft;
    wb_valid = valid; wb_is_move = mv; sat_en = sat; cc32 = cc;
    ovf36_in = ovf; carry36_in = c36; carry32_in = c32; l_clr = clr; res_in = raw;
    hit = !mv && sat && !in_word(raw);
    st  = hit ? (as_signed(raw) > 0 ? 36'h0_7FFF_FFFF : 36'hF_8000_0000) : raw;
    vv  = hit || (cc ? !in_word(raw) : ovf);
    m_l = (m_l && !clr) || (valid && !mv && vv);
    if (valid) m_acc = st;
    if (valid && !mv) begin
      m_e = !in_word(st);
      m_u = !hit && (st[31] == st[30]);
      m_n = cc ? st[31] : (as_signed(st) < 0);
      m_z = cc ? (st[31:0] == 32'd0) : (st == 36'd0);
      m_v = vv;
      m_c = cc ? c32 : c36;
    end
    at = !valid ? "R2 acc" : mv ? "R5 acc" : !sat ? "R4 acc" : "R3 acc";
    ft = !valid ? "R2" : mv ? "R5" : "R2";
    @(negedge clk);
    check_all(at, ft);
  endtask

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [28:0] fill;
    int k;
    rst_n = 1'b0; wb_valid = 0; wb_is_move = 0; sat_en = 0; cc32 = 0;
    ovf36_in = 0; carry36_in = 0; carry32_in = 0; l_clr = 0; res_in = '0;
    m_acc = '0; {m_e, m_u, m_n, m_z, m_v, m_c, m_l} = '0;
    repeat (3) @(negedge clk);
    check_all("R1 acc", "R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 acc", "R1");

    // clamp boundaries, limiter on, both modes
    for (int cc = 0; cc < 2; cc++) begin
      step(1, 0, 1, cc[0], 0, 0, 0, 0, 36'h0_7FFF_FFFF);
      step(1, 0, 1, cc[0], 0, 0, 0, 0, 36'h0_8000_0000);
      step(1, 0, 1, cc[0], 0, 0, 0, 1, 36'hF_8000_0000);
      step(1, 0, 1, cc[0], 0, 0, 0, 0, 36'hF_7FFF_FFFF);
      step(1, 0, 1, cc[0], 1, 1, 1, 0, 36'h7_FFFF_FFFF);
      step(1, 0, 1, cc[0], 1, 0, 1, 0, 36'h8_0000_0000);
      step(1, 0, 0, cc[0], 1, 0, 1, 0, 36'h1_0000_0000);
      step(1, 1, 1, cc[0], 1, 1, 0, 0, 36'h5_1234_5678);
    end
    // hold without write-back; L cleared alone; clear meeting a new overflow
    step(0, 0, 1, 1, 1, 1, 1, 0, 36'h9_0000_0001);
    step(0, 0, 0, 0, 0, 0, 0, 1, 36'h0);
    step(1, 0, 1, 0, 0, 0, 0, 0, 36'h0_1000_0000);
    step(1, 0, 1, 1, 0, 0, 0, 1, 36'h3_0000_0000);
    step(1, 1, 0, 1, 0, 0, 0, 1, 36'hA_0000_0000);

    // sweep: guard+top bits x low fill x {move, sat, cc}
    k = 0;
    for (int hi = 0; hi < 128; hi++) begin
      for (int pat = 0; pat < 3; pat++) begin
        fill = (pat == 0) ? 29'd0 : (pat == 1) ? '1 : 29'h0AAA_AAAA;
        for (int m = 0; m < 8; m++) begin
          k++;
          step(1, m[2], m[1], m[0], hi[0] ^ pat[0], hi[1], hi[2] ^ m[0],
               (k % 17) == 0, {hi[6:0], fill});
          if ((k % 50) == 0)
            step(0, 0, 1, m[0], 1, 1, 1, 0, ~{hi[6:0], fill});
        end
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule